// File: doc/BRIEF.md
# Programmable Serial Test-Pattern Generator

This block is the transmit-side pattern source of a bit-error-rate tester. It holds a 32-stage shift register. On every enabled clock it moves that register one place and sends one bit on its serial output. A pair of 5-bit fields chooses a length stage and a tap stage. In pseudo-random mode the new bit is the XOR of those two stages, which gives a two-tap polynomial x^n + x^y + 1. In repetitive mode the new bit is the length stage alone, so a programmed word of n bits goes round and round.

A quasi-random override sets aside the fields, the mode select and the seed. With the override on, the block runs the 20-stage polynomial x^20 + x^17 + 1. It forces its output to one whenever the fourteen bits queued behind the current one are all zero, so no run of zeros at the output is longer than fourteen bits. A load strobe writes a fresh seed or pattern into the register. Loading an all-zero seed in pseudo-random mode would lock the register, so the block replaces such a seed with a single one.

Top module: `prbs_pattern_gen`

## Requirements
- R1: The length stage is n = `len_sel` + 1 and the tap stage is y = `tap_sel` + 1. Stage k is the bit that was shifted in k-1 enabled clocks earlier. `dout` shows stage n.
- R2: With `rep_mode` = 0 and `qrss_en` = 0, each enabled clock shifts the register up by one stage. The XOR of stage n and stage y enters stage 1.
- R3: With `rep_mode` = 1 and `qrss_en` = 0, stage n alone is fed back and `tap_sel` has no effect. After a load, `dout` repeats with period n.
- R4: A high `ld` loads `seed` into stages 1..n, with bit k-1 going to stage k, and clears the stages above n. The load wins over a shift in the same cycle. When `qrss_en` = 1, a load instead fills stages 1..20 with ones and clears the rest.
- R5: A load in pseudo-random mode whose stages 1..n would all be zero puts a one in stage 1 instead.
- R6: With `en` = 0 and `ld` = 0, the register holds its contents.
- R7: With `qrss_en` = 1, the block acts as R2 with n = 20 and y = 17, whatever `len_sel`, `tap_sel` and `rep_mode` hold.
- R8: With `qrss_en` = 1, `dout` is forced to 1 while stages 6 through 19 are all zero. No run of more than 14 zeros then appears at `dout`.
- R9: Reset sets every stage to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Clock enable for shifting |
| ld | input | 1 | Load strobe for the seed/pattern |
| len_sel | input | 5 | Length stage minus one |
| tap_sel | input | 5 | Tap stage minus one |
| rep_mode | input | 1 | 1 selects repetitive mode, 0 pseudo-random |
| qrss_en | input | 1 | Quasi-random override |
| seed | input | 32 | Seed or pattern word |
| dout | output | 1 | Serial pattern bit |

## Verification
The feedback properties assume that `len_sel`, `rep_mode` and `qrss_en` have not changed since the clock edge they refer to. The zero-run property assumes the quasi-random override stays on without a reload for the whole run it counts. The bench changes settings only together with a load, or in phases whose checks do not rest on those settings. The one exception is `tap_sel`, which it moves freely while the tap is ignored. A reference model steps each future output on its own, and the bench compares against it every cycle. The bench also measures output zero runs and repetition periods directly.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
    localparam int unsigned QRSS_LEN = 20;
    localparam int unsigned QRSS_TAP = 17;
    localparam int unsigned QRSS_RUN = 14;
endpackage

// File: rtl/prbs_cfg_sel.sv
module prbs_cfg_sel #(
    parameter int unsigned SEL_W = 5
) (
    input  logic [SEL_W-1:0] len_sel,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic             rep_mode,
    input  logic             qrss_en,
    output logic [SEL_W-1:0] len_idx,
    output logic [SEL_W-1:0] tap_idx,
    output logic             rep_eff
);
    import prbs_gen_pkg::*;
    localparam logic [SEL_W-1:0] Q_LEN_IDX = SEL_W'(QRSS_LEN - 1);
    localparam logic [SEL_W-1:0] Q_TAP_IDX = SEL_W'(QRSS_TAP - 1);

    always_comb begin
        if (qrss_en) begin
            len_idx = Q_LEN_IDX;
            tap_idx = Q_TAP_IDX;
            rep_eff = 1'b0;
        end else begin
            len_idx = len_sel;
            tap_idx = tap_sel;
            rep_eff = rep_mode;
        end
    end
endmodule

// File: rtl/prbs_tap_fb.sv
module prbs_tap_fb #(
    parameter int unsigned W     = 32,
    parameter int unsigned SEL_W = 5
) (
    input  logic [W-1:0]     sr,
    input  logic [SEL_W-1:0] len_idx,
    input  logic [SEL_W-1:0] tap_idx,
    input  logic             rep_eff,
    output logic             raw_bit,
    output logic             fb_bit
);
    always_comb begin
        raw_bit = sr[len_idx];
        fb_bit  = rep_eff ? raw_bit : (raw_bit ^ sr[tap_idx]);
    end
endmodule

// File: rtl/prbs_seed_prep.sv
module prbs_seed_prep #(
    parameter int unsigned W     = 32,
    parameter int unsigned SEL_W = 5
) (
    input  logic [W-1:0]     seed,
    input  logic [SEL_W-1:0] len_idx,
    input  logic             rep_eff,
    input  logic             qrss_en,
    output logic [W-1:0]     load_val
);
    import prbs_gen_pkg::*;
    localparam logic [W-1:0] Q_FILL = W'((64'd1 << QRSS_LEN) - 64'd1);

    logic [W-1:0] len_mask;
    logic [W-1:0] trunc;

    always_comb begin
        for (int k = 0; k < int'(W); k++) begin
            len_mask[k] = (k <= int'(len_idx));
        end
        trunc = seed & len_mask;
        if (qrss_en) begin
            load_val = Q_FILL;
        end else if (!rep_eff && (trunc == '0)) begin
            load_val = W'(1);
        end else begin
            load_val = trunc;
        end
    end
endmodule

// File: rtl/prbs_zero_guard.sv
module prbs_zero_guard #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] sr,
    input  logic         raw_bit,
    input  logic         qrss_en,
    output logic         dout
);
    import prbs_gen_pkg::*;
    localparam int unsigned HI = QRSS_LEN - 2;
    localparam int unsigned LO = QRSS_LEN - 1 - QRSS_RUN;

    logic quiet_ahead;

    always_comb begin
        quiet_ahead = (sr[HI:LO] == '0);
        dout        = raw_bit | (qrss_en & quiet_ahead);
    end
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen #(
    parameter int unsigned W     = 32,
    parameter int unsigned SEL_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ld,
    input  logic [SEL_W-1:0] len_sel,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic             rep_mode,
    input  logic             qrss_en,
    input  logic [W-1:0]     seed,
    output logic             dout
);
    import prbs_gen_pkg::*;

    typedef struct packed {
        logic [W-1:0] sr;
    } gen_state_t;

    gen_state_t       st_d, st_q;
    logic [SEL_W-1:0] len_idx, tap_idx;
    logic             rep_eff, raw_bit, fb_bit;
    logic [W-1:0]     load_val;

    prbs_cfg_sel #(.SEL_W(SEL_W)) u_cfg (
        .len_sel(len_sel), .tap_sel(tap_sel), .rep_mode(rep_mode),
        .qrss_en(qrss_en), .len_idx(len_idx), .tap_idx(tap_idx),
        .rep_eff(rep_eff)
    );

    prbs_tap_fb #(.W(W), .SEL_W(SEL_W)) u_fb (
        .sr(st_q.sr), .len_idx(len_idx), .tap_idx(tap_idx),
        .rep_eff(rep_eff), .raw_bit(raw_bit), .fb_bit(fb_bit)
    );

    prbs_seed_prep #(.W(W), .SEL_W(SEL_W)) u_seed (
        .seed(seed), .len_idx(len_idx), .rep_eff(rep_eff),
        .qrss_en(qrss_en), .load_val(load_val)
    );

    prbs_zero_guard #(.W(W)) u_guard (
        .sr(st_q.sr), .raw_bit(raw_bit), .qrss_en(qrss_en), .dout(dout)
    );

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.sr = load_val;
        end else if (en) begin
            st_d.sr = {st_q.sr[W-2:0], fb_bit};
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.sr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // Output zero-run counter used only by the R8 property
    logic [4:0] zrun_q;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            zrun_q <= '0;
        end else if (ld || !qrss_en) begin
            zrun_q <= '0;
        end else if (en) begin
            if (dout) zrun_q <= '0;
            else if (zrun_q != 5'd31) zrun_q <= zrun_q + 5'd1;
        end
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !ld) |=> $stable(st_q.sr));

    a_r2_shift: assert property (@(posedge clk) disable iff (rst)
        (en && !ld) |=> (st_q.sr[W-1:1] == $past(st_q.sr[W-2:0])));

    a_r2_prbs_fb: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && !rep_mode && !qrss_en) |=>
        (st_q.sr[0] == ($past(st_q.sr[len_sel]) ^ $past(st_q.sr[tap_sel]))));

    a_r3_rep_fb: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && rep_mode && !qrss_en) |=>
        (st_q.sr[0] == $past(st_q.sr[len_sel])));

    a_r5_nonzero_seed: assert property (@(posedge clk) disable iff (rst)
        (ld && !qrss_en && !rep_mode) |=> (st_q.sr != '0));

    a_r4_qrss_fill: assert property (@(posedge clk) disable iff (rst)
        (ld && qrss_en) |=> (st_q.sr[QRSS_LEN-1:0] == '1));

    a_r8_zero_run: assert property (@(posedge clk) disable iff (rst)
        zrun_q <= 5'(QRSS_RUN));
endmodule

// File: tb/sim_prbs_pattern_gen.sv
module sim_prbs_pattern_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, ld = 1'b0, rep_mode = 1'b0, qrss_en = 1'b0;
    logic [4:0]  len_sel = '0, tap_sel = '0;
    logic [31:0] seed = '0;
    logic        dout;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] m;
    int zrun = 0;
    logic hist[$];

    always #5 clk = ~clk;

    prbs_pattern_gen u0 (
        .clk(clk), .rst(rst), .en(en), .ld(ld), .len_sel(len_sel),
        .tap_sel(tap_sel), .rep_mode(rep_mode), .qrss_en(qrss_en),
        .seed(seed), .dout(dout)
    );

    function automatic int eff_n();
        return qrss_en ? 20 : int'(len_sel) + 1;
    endfunction
    function automatic int eff_y();
        return qrss_en ? 17 : int'(tap_sel) + 1;
    endfunction
    function automatic bit eff_rep();
        return qrss_en ? 1'b0 : rep_mode;
    endfunction

    function automatic logic [31:0] adv(logic [31:0] s, int n, int y, bit rep);
        logic f;
        f = rep ? s[n-1] : (s[n-1] ^ s[y-1]);
        return {s[30:0], f};
    endfunction

    function automatic logic expect_out();
        logic [31:0] t;
        bit allz;
        if (!qrss_en) return m[eff_n()-1];
        t = m;
        allz = 1;
        for (int i = 0; i < 14; i++) begin
            t = adv(t, 20, 17, 1'b0);
            if (t[19]) allz = 0;
        end
        return m[19] | allz;
    endfunction

    function automatic logic [31:0] load_model();
        logic [31:0] v;
        if (qrss_en) return 32'h000F_FFFF;
        v = '0;
        for (int k = 0; k < eff_n(); k++) v[k] = seed[k];
        if (!eff_rep() && v == '0) v = 32'h1;
        return v;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: model follows the posedge, compare at the next negedge
    task automatic cyc(input string req);
        @(posedge clk);
        if (rst) m = '1;
        else if (ld) m = load_model();
        else if (en) m = adv(m, eff_n(), eff_y(), eff_rep());
        @(negedge clk);
        check(dout, expect_out(), req);
    endtask

    task automatic setup(input int n, input int y, input bit rep, input bit q,
                         input logic [31:0] s);
        len_sel = 5'(n - 1);
        tap_sel = 5'(y - 1);
        rep_mode = rep;
        qrss_en = q;
        seed = s;
        ld = 1;
        en = 1;
        cyc("R4");
        ld = 0;
    endtask

    task automatic run_prbs(input int n, input int y, input logic [31:0] s,
                            input int len, input string req);
        setup(n, y, 1'b0, 1'b0, s);
        for (int i = 0; i < len; i++) cyc(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic prev;
        int ones;
        // R9: reset fills ones, output stage 1 (len_sel=0, R1)
        cyc("R9");
        cyc("R9");
        @(negedge clk);
        rst = 0;
        check(dout, 1'b1, "R9");

        // R1/R2: several polynomials, including tap above the length stage
        run_prbs(15, 14, 32'h0000_1234, 400, "R2");
        run_prbs(23, 18, 32'h005A_5A5A, 400, "R2");
        run_prbs(32, 22, 32'hDEAD_BEEF, 300, "R1");
        run_prbs(5, 9, 32'h0000_0013, 200, "R1");

        // R6: enable toggling, output frozen while en is low
        setup(7, 6, 1'b0, 1'b0, 32'h0000_0041);
        for (int i = 0; i < 300; i++) begin
            prev = dout;
            en = ($urandom % 3) != 0;
            cyc("R6");
            if (!en) check(dout, prev, "R6");
        end
        en = 1;

        // R4: reload mid-run with upper seed bits that must be dropped
        run_prbs(9, 5, 32'hFFFF_F0AB, 50, "R4");
        setup(9, 5, 1'b0, 1'b0, 32'hFFFF_F0AB);
        for (int i = 0; i < 100; i++) cyc("R4");

        // R5: zero seed replaced by a single one
        setup(11, 9, 1'b0, 1'b0, 32'hFFFF_F800);
        ones = 0;
        for (int i = 0; i < 100; i++) begin
            cyc("R5");
            if (dout) ones++;
        end
        check(ones > 0, 1'b1, "R5");

        // R3: repetitive pattern, tap moved every cycle, period 8
        setup(8, 3, 1'b1, 1'b0, 32'h0000_00A5);
        hist.delete();
        for (int i = 0; i < 200; i++) begin
            tap_sel = 5'($urandom);
            hist.push_back(dout);
            if (hist.size() > 8) begin
                check(dout, hist[0], "R3");
                void'(hist.pop_front());
            end
            cyc("R3");
        end

        // R7/R8: quasi-random mode, other settings ignored, zero runs bounded
        setup(5, 2, 1'b1, 1'b1, 32'h0);
        zrun = 0;
        for (int i = 0; i < 60000; i++) begin
            if (i % 977 == 0) begin
                len_sel = 5'($urandom);
                tap_sel = 5'($urandom);
                rep_mode = 1'($urandom);
            end
            cyc("R7");
            zrun = dout ? 0 : zrun + 1;
            check(zrun <= 14, 1'b1, "R8");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule